// File: doc/BRIEF.md
# Time-Multiplexed Cascaded Biquad Filter

This block filters a stream of 16-bit signed samples through a chain of up to 25 second-order recursive sections. It has one multiply-add section datapath instead of 25. Each accepted sample makes one trip through that datapath for every section in use. The result of one trip goes back to the datapath input as the sample for the next section. A section index steps through the chain and picks that section's coefficients and its two state words. The state words live in indexed storage that holds one entry per section.

Coefficients come from a table that is loaded through a plain write port. Each section has five coefficients, all fixed-point with 14 fractional bits. A run input starts and stops a measurement: holding it low wipes the state of every section.

The input is valid/ready. The block refuses a new sample for as long as one is still moving through the chain, so back-pressure lasts 4·n cycles per sample. The output is a single-cycle valid pulse with data, and it has no back-pressure. A consumer must take the sample in the cycle the pulse is high.

Top module: `tdm_biquad_cascade`

## Requirements
- R1: `in_ready` is high exactly when `run` is high and no sample is in flight. A sample is taken on a rising edge where `in_valid` and `in_ready` are both high. Samples offered while `in_ready` is low are ignored and leave the output stream unchanged.
- R2: `out_valid` is high for exactly one cycle. It rises at the 4·n-th rising edge after the accepting edge, where n is the effective section count. `out_data` holds the result of the last section in that cycle.
- R3: `sect_count` is sampled on the accepting edge. A value of 0 acts as 1, and a value above 25 acts as 25.
- R4: Section i (0-based) computes its output y = ff0·x + s1 at full precision. It then updates its state as s1 ← ff1·x − fb1·y + s2 and s2 ← ff2·x − fb2·y, where y is the rounded section output. The transfer function is therefore (ff0 + ff1·z⁻¹ + ff2·z⁻²) / (1 + fb1·z⁻¹ + fb2·z⁻²).
- R5: Each section output is formed from the full-precision sum by adding 2^13 and shifting right by 14 with sign. The value is then saturated to the range −32768…32767.
- R6: Coefficients are signed 16-bit values with 14 fractional bits. A write sets one coefficient when `coef_we` is high, chosen by `coef_sect` (0…24) and `coef_slot`. The slot codes are 0 = ff0, 1 = ff1, 2 = ff2, 3 = fb1, 4 = fb2. Writes with `coef_sect` ≥ 25 or `coef_slot` ≥ 5 are ignored.
- R7: After reset every section is an identity: ff0 = 16384 and all other coefficients 0. All state is zero, `out_valid` is low, and `out_data` is 0.
- R8: While `run` is low, all section state is zero, any sample in flight is dropped without an `out_valid` pulse, and `in_ready` is low. Coefficients are kept.
- R9: A section's state is written back only when its pass has left the datapath. The state carries from one sample to the next, so the filter is recursive across samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | High to filter; low clears all section state |
| sect_count | input | 5 | Number of sections to apply (0 acts as 1, above 25 acts as 25) |
| coef_we | input | 1 | Coefficient write strobe |
| coef_sect | input | 5 | Section index of the coefficient write |
| coef_slot | input | 3 | Coefficient slot code (0 ff0, 1 ff1, 2 ff2, 3 fb1, 4 fb2) |
| coef_data | input | 16 | Signed coefficient value, 14 fractional bits |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | Block can take a sample |
| in_data | input | 16 | Signed input sample |
| out_valid | output | 1 | One-cycle result strobe |
| out_data | output | 16 | Signed filtered sample |

## Verification
A result is due at the 4·n-th rising edge after the accepting edge, for example 4, 12 or 100 edges for n = 1, 3 or 25. The bench drives inputs and samples outputs on falling edges. It counts falling edges after acceptance and compares that count with 4·n. It checks `out_data` in the first cycle `out_valid` is seen and confirms the pulse is gone one cycle later. Coefficient writes take effect one edge after the strobe, and a low `run` acts at the next edge. Each check is therefore made only after a full quiet cycle has passed since the stimulus.

// File: rtl/tdmb_pkg.sv
package tdmb_pkg;
  localparam int SAMPLE_W  = 16;
  localparam int COEF_W    = 16;
  localparam int NUM_SLOTS = 5;

  typedef enum logic [2:0] {
    SLOT_FF0 = 3'd0,
    SLOT_FF1 = 3'd1,
    SLOT_FF2 = 3'd2,
    SLOT_FB1 = 3'd3,
    SLOT_FB2 = 3'd4
  } coef_slot_e;

  typedef struct packed {
    logic signed [COEF_W-1:0] ff0;
    logic signed [COEF_W-1:0] ff1;
    logic signed [COEF_W-1:0] ff2;
    logic signed [COEF_W-1:0] fb1;
    logic signed [COEF_W-1:0] fb2;
  } coef_set_t;
endpackage

// File: rtl/tdmb_coef_table.sv
module tdmb_coef_table
  import tdmb_pkg::*;
#(
  parameter int MAX_SECT = 25,
  parameter int FRAC     = 14,
  parameter int IW       = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [IW-1:0]            wr_sect,
  input  logic [2:0]               wr_slot,
  input  logic signed [COEF_W-1:0] wr_data,
  input  logic [IW-1:0]            rd_sect,
  output coef_set_t                rd_set
);
  localparam logic signed [COEF_W-1:0] UNITY = COEF_W'(64'd1 << FRAC);

  logic signed [COEF_W-1:0] tbl [MAX_SECT][NUM_SLOTS];
  logic wr_ok;

  // R6: out-of-range section or slot codes never touch the table
  assign wr_ok = we && (int'(wr_sect) < MAX_SECT) && (int'(wr_slot) < NUM_SLOTS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < MAX_SECT; s++) begin
        for (int k = 0; k < NUM_SLOTS; k++) begin
          tbl[s][k] <= (k == int'(SLOT_FF0)) ? UNITY : '0;
        end
      end
    end else if (wr_ok) begin
      tbl[wr_sect][wr_slot] <= wr_data;
    end
  end

  always_comb begin
    rd_set.ff0 = tbl[rd_sect][SLOT_FF0];
    rd_set.ff1 = tbl[rd_sect][SLOT_FF1];
    rd_set.ff2 = tbl[rd_sect][SLOT_FF2];
    rd_set.fb1 = tbl[rd_sect][SLOT_FB1];
    rd_set.fb2 = tbl[rd_sect][SLOT_FB2];
  end
endmodule

// File: rtl/tdmb_state_mem.sv
module tdmb_state_mem #(
  parameter int MAX_SECT = 25,
  parameter int AW       = 36,
  parameter int IW       = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic [IW-1:0]        rd_idx,
  output logic signed [AW-1:0] rd_s1,
  output logic signed [AW-1:0] rd_s2,
  input  logic                 we,
  input  logic [IW-1:0]        wr_idx,
  input  logic signed [AW-1:0] wr_s1,
  input  logic signed [AW-1:0] wr_s2
);
  logic signed [AW-1:0] s1_q [MAX_SECT];
  logic signed [AW-1:0] s2_q [MAX_SECT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < MAX_SECT; s++) begin
        s1_q[s] <= '0;
        s2_q[s] <= '0;
      end
    end else if (clr) begin
      for (int s = 0; s < MAX_SECT; s++) begin
        s1_q[s] <= '0;
        s2_q[s] <= '0;
      end
    end else if (we) begin
      s1_q[wr_idx] <= wr_s1;
      s2_q[wr_idx] <= wr_s2;
    end
  end

  assign rd_s1 = s1_q[rd_idx];
  assign rd_s2 = s2_q[rd_idx];

  // R8: after a clear cycle every entry reads back as zero
  p_clear_reads_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (rd_s1 == '0 && rd_s2 == '0));
endmodule

// File: rtl/tdmb_section_pipe.sv
module tdmb_section_pipe
  import tdmb_pkg::*;
#(
  parameter int FRAC = 14,
  parameter int AW   = 36
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       flush,
  input  logic                       issue,
  input  logic signed [SAMPLE_W-1:0] x,
  input  coef_set_t                  cf,
  input  logic signed [AW-1:0]       s1,
  input  logic signed [AW-1:0]       s2,
  output logic                       done,
  output logic signed [SAMPLE_W-1:0] y,
  output logic signed [AW-1:0]       s1_next,
  output logic signed [AW-1:0]       s2_next
);
  localparam logic signed [AW-1:0] HALF = AW'(64'd1 << (FRAC - 1));
  localparam logic signed [AW-1:0] YMAX = $signed({{(AW-SAMPLE_W+1){1'b0}}, {(SAMPLE_W-1){1'b1}}});
  localparam logic signed [AW-1:0] YMIN = $signed({{(AW-SAMPLE_W+1){1'b1}}, {(SAMPLE_W-1){1'b0}}});

  function automatic logic signed [AW-1:0] ext_s(input logic signed [SAMPLE_W-1:0] v);
    return $signed({{(AW-SAMPLE_W){v[SAMPLE_W-1]}}, v});
  endfunction

  function automatic logic signed [AW-1:0] ext_c(input logic signed [COEF_W-1:0] v);
    return $signed({{(AW-COEF_W){v[COEF_W-1]}}, v});
  endfunction

  logic v1, v2, v3;
  // stage 1: feedforward products and state fetch
  logic signed [AW-1:0]       p0_q, p1_q, p2_q, s1_q, s2_q;
  logic signed [COEF_W-1:0]   fb1_q, fb2_q;
  // stage 2: rounded section output and partial sums
  logic signed [SAMPLE_W-1:0] y2_q;
  logic signed [AW-1:0]       sum1_q, p2_q2;
  logic signed [COEF_W-1:0]   fb1_q2, fb2_q2;
  // stage 2 combinational rounding and saturation (R5)
  logic signed [AW-1:0]       acc, rnd, shf;
  logic signed [SAMPLE_W-1:0] ysat;

  always_comb begin
    acc = p0_q + s1_q;
    rnd = acc + HALF;
    shf = rnd >>> FRAC;
    if (shf > YMAX)      ysat = YMAX[SAMPLE_W-1:0];
    else if (shf < YMIN) ysat = YMIN[SAMPLE_W-1:0];
    else                 ysat = shf[SAMPLE_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
      v3 <= 1'b0;
    end else if (flush) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
      v3 <= 1'b0;
    end else begin
      v1 <= issue;
      v2 <= v1;
      v3 <= v2;
    end
  end

  always_ff @(posedge clk) begin
    if (issue) begin
      p0_q  <= ext_s(x) * ext_c(cf.ff0);
      p1_q  <= ext_s(x) * ext_c(cf.ff1);
      p2_q  <= ext_s(x) * ext_c(cf.ff2);
      s1_q  <= s1;
      s2_q  <= s2;
      fb1_q <= cf.fb1;
      fb2_q <= cf.fb2;
    end
    if (v1) begin
      y2_q   <= ysat;
      sum1_q <= p1_q + s2_q;
      p2_q2  <= p2_q;
      fb1_q2 <= fb1_q;
      fb2_q2 <= fb2_q;
    end
    if (v2) begin
      y       <= y2_q;
      s1_next <= sum1_q - ext_c(fb1_q2) * ext_s(y2_q);
      s2_next <= p2_q2  - ext_c(fb2_q2) * ext_s(y2_q);
    end
  end

  assign done = v3;

  // R9: a pass enters only an empty datapath, so state is never read stale
  p_issue_into_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    issue |-> !(v1 || v2 || v3));
  p_single_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({v1, v2, v3}));
endmodule

// File: rtl/tdm_biquad_cascade.sv
module tdm_biquad_cascade
  import tdmb_pkg::*;
#(
  parameter  int MAX_SECT = 25,
  parameter  int FRAC     = 14,
  parameter  int GUARD    = 4,
  localparam int IDXW     = (MAX_SECT > 1) ? $clog2(MAX_SECT) : 1,
  localparam int CNTW     = $clog2(MAX_SECT + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 run,
  input  logic [CNTW-1:0]      sect_count,
  input  logic                 coef_we,
  input  logic [IDXW-1:0]      coef_sect,
  input  logic [2:0]           coef_slot,
  input  logic [COEF_W-1:0]    coef_data,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [SAMPLE_W-1:0]  in_data,
  output logic                 out_valid,
  output logic [SAMPLE_W-1:0]  out_data
);
  localparam int AW = SAMPLE_W + COEF_W + GUARD;

  logic                       busy, tok;
  logic signed [SAMPLE_W-1:0] cur_x;
  logic [IDXW-1:0]            cur_idx, last_idx, last_sel;
  logic                       accept;

  coef_set_t                  cf;
  logic signed [AW-1:0]       st_s1, st_s2, nx_s1, nx_s2;
  logic                       pipe_done;
  logic signed [SAMPLE_W-1:0] pipe_y;

  assign in_ready = run && !busy;                 // R1
  assign accept   = in_valid && in_ready;

  // R3: clamp the requested section count into 1..MAX_SECT
  always_comb begin
    if (sect_count == '0)                last_sel = '0;
    else if (int'(sect_count) > MAX_SECT) last_sel = IDXW'(MAX_SECT - 1);
    else                                 last_sel = IDXW'(int'(sect_count) - 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      tok       <= 1'b0;
      cur_x     <= '0;
      cur_idx   <= '0;
      last_idx  <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (!run) begin                       // R8: drop any sample in flight
      busy      <= 1'b0;
      tok       <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      tok       <= 1'b0;
      if (accept) begin
        busy     <= 1'b1;
        tok      <= 1'b1;
        cur_x    <= $signed(in_data);
        cur_idx  <= '0;
        last_idx <= last_sel;
      end else if (pipe_done) begin
        if (cur_idx == last_idx) begin
          busy      <= 1'b0;
          out_valid <= 1'b1;                       // R2
          out_data  <= pipe_y;
        end else begin
          cur_idx <= cur_idx + 1'b1;
          cur_x   <= pipe_y;                       // feed result back as next section input
          tok     <= 1'b1;
        end
      end
    end
  end

  tdmb_coef_table #(.MAX_SECT(MAX_SECT), .FRAC(FRAC), .IW(IDXW)) u_coef (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (coef_we),
    .wr_sect (coef_sect),
    .wr_slot (coef_slot),
    .wr_data ($signed(coef_data)),
    .rd_sect (cur_idx),
    .rd_set  (cf)
  );

  tdmb_state_mem #(.MAX_SECT(MAX_SECT), .AW(AW), .IW(IDXW)) u_state (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (!run),
    .rd_idx (cur_idx),
    .rd_s1  (st_s1),
    .rd_s2  (st_s2),
    .we     (pipe_done && run),                    // R9: write-back at end of pass
    .wr_idx (cur_idx),
    .wr_s1  (nx_s1),
    .wr_s2  (nx_s2)
  );

  tdmb_section_pipe #(.FRAC(FRAC), .AW(AW)) u_pipe (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush   (!run),
    .issue   (tok),
    .x       (cur_x),
    .cf      (cf),
    .s1      (st_s1),
    .s2      (st_s2),
    .done    (pipe_done),
    .y       (pipe_y),
    .s1_next (nx_s1),
    .s2_next (nx_s2)
  );

  // R2: result strobe never lasts two cycles
  p_out_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);
  // R1: an accepted sample blocks the next one
  p_accept_blocks_r1: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !in_ready);
  // R8: no result can emerge from a cleared run
  p_run_low_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !out_valid);
  // R3: the section index never passes the clamped count
  p_index_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cur_idx <= last_idx && int'(last_idx) < MAX_SECT));
  // R9: a finished pass only ever belongs to a sample in flight
  p_done_in_flight_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pipe_done |-> busy);
endmodule

// File: tb/tdm_biquad_cascade_bench.sv
module tdm_biquad_cascade_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run = 1'b1;
  logic [4:0]  sect_count = 5'd1;
  logic        coef_we = 1'b0;
  logic [4:0]  coef_sect = '0;
  logic [2:0]  coef_slot = '0;
  logic [15:0] coef_data = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_data = '0;
  logic        out_valid;
  logic [15:0] out_data;

  int checks = 0;
  int errors = 0;

  longint cm [25][5];
  longint s1m [25];
  longint s2m [25];

  always #4 clk = ~clk;

  tdm_biquad_cascade u_tdm_biquad_cascade (
    .clk(clk), .rst_n(rst_n), .run(run), .sect_count(sect_count),
    .coef_we(coef_we), .coef_sect(coef_sect), .coef_slot(coef_slot), .coef_data(coef_data),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint sat_round(input longint acc);
    longint r;
    r = (acc + 8192) >>> 14;
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return r;
  endfunction

  function automatic int eff_count(input int n);
    if (n == 0) return 1;
    if (n > 25) return 25;
    return n;
  endfunction

  function automatic longint model_sample(input longint xin, input int n);
    longint x, y;
    x = xin;
    for (int i = 0; i < eff_count(n); i++) begin
      y = sat_round(cm[i][0] * x + s1m[i]);
      s1m[i] = cm[i][1] * x - cm[i][3] * y + s2m[i];
      s2m[i] = cm[i][2] * x - cm[i][4] * y;
      x = y;
    end
    return x;
  endfunction

  function automatic void model_clear_state();
    for (int i = 0; i < 25; i++) begin
      s1m[i] = 0;
      s2m[i] = 0;
    end
  endfunction

  task automatic write_coef(input int s, input int slot, input int val);
    @(negedge clk);
    coef_we = 1'b1;
    coef_sect = 5'(s);
    coef_slot = 3'(slot);
    coef_data = 16'(val);
    @(negedge clk);
    coef_we = 1'b0;
    if (s < 25 && slot < 5) cm[s][slot] = longint'(val);
  endtask

  task automatic offer(input longint x, input int n);
    @(negedge clk);
    in_valid = 1'b1;
    in_data = 16'(x);
    sect_count = 5'(n);
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  task automatic await_result(output longint y, output int lat);
    lat = -1;
    y = 0;
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      if (out_valid) begin
        lat = k;
        y = longint'($signed(out_data));
        break;
      end
    end
  endtask

  task automatic sample_check(input longint x, input int n, input string tag);
    longint y, exp;
    int lat;
    check(in_ready === 1'b1, {tag, " R1 ready before offer"}, longint'(in_ready), 1);
    exp = model_sample(x, n);
    offer(x, n);
    await_result(y, lat);
    check(lat == 4 * eff_count(n), {tag, " R2 latency"}, lat, 4 * eff_count(n));
    check(y == exp, {tag, " data"}, y, exp);
    @(negedge clk);
    check(out_valid === 1'b0, {tag, " R2 one-cycle pulse"}, longint'(out_valid), 0);
  endtask

  task automatic t_reset_r7();
    check(out_valid === 1'b0, "R7 out_valid after reset", longint'(out_valid), 0);
    check(out_data === 16'd0, "R7 out_data after reset", longint'(out_data), 0);
    check(in_ready === 1'b1, "R1 in_ready idle after reset", longint'(in_ready), 1);
    sample_check(1234, 1, "R7 identity n=1");
    sample_check(-20000, 25, "R7 identity n=25");
  endtask

  task automatic t_count_r3();
    sample_check(777, 3, "R3 n=3");
    sample_check(-55, 0, "R3 n=0 acts as 1");
    sample_check(4321, 31, "R3 n=31 acts as 25");
  endtask

  task automatic t_busy_ignore_r1();
    longint y, exp;
    int lat;
    exp = model_sample(3000, 3);
    offer(3000, 3);
    in_valid = 1'b1;
    in_data = 16'd999;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      check(in_ready === 1'b0, "R1 ready low while busy", longint'(in_ready), 0);
    end
    in_valid = 1'b0;
    await_result(y, lat);
    check(lat == 6, "R1 latency unaffected by ignored offer", lat, 6);
    check(y == exp, "R1 ignored offer leaves output", y, exp);
    @(negedge clk);
    @(negedge clk);
    check(out_valid === 1'b0, "R1 no result from ignored offer", longint'(out_valid), 0);
  endtask

  task automatic t_round_sat_r5();
    write_coef(0, 0, 8192);
    sample_check(3, 1, "R5 round 1.5 up");
    sample_check(-3, 1, "R5 round -1.5 up");
    sample_check(5, 1, "R5 round 2.5 up");
    write_coef(0, 0, 32767);
    sample_check(30000, 1, "R5 saturate high");
    sample_check(-30000, 1, "R5 saturate low");
  endtask

  task automatic t_recursion_r4();
    write_coef(0, 0, 8192);
    write_coef(0, 1, 8192);
    write_coef(0, 2, 4096);
    write_coef(0, 3, -8192);
    write_coef(0, 4, 4096);
    sample_check(8000, 1, "R4 impulse step0");
    sample_check(0, 1, "R9 state carried step1");
    sample_check(0, 1, "R9 state carried step2");
    sample_check(-4000, 1, "R4 step3");
    sample_check(0, 1, "R4 step4");
  endtask

  task automatic t_cascade_r6();
    write_coef(1, 0, 16384);
    write_coef(1, 1, -4096);
    write_coef(1, 2, 0);
    write_coef(1, 3, 4096);
    write_coef(1, 4, 0);
    sample_check(5000, 2, "R6 cascade s0");
    sample_check(-3000, 2, "R6 cascade s1");
    write_coef(31, 0, 0);
    write_coef(25, 1, 0);
    write_coef(0, 5, 0);
    write_coef(0, 7, 0);
    sample_check(1000, 2, "R6 ignored writes s2");
    sample_check(0, 2, "R6 ignored writes s3");
  endtask

  task automatic t_run_clear_r8();
    sample_check(6000, 2, "R8 warm up");
    offer(2500, 2);
    @(negedge clk);
    @(negedge clk);
    run = 1'b0;
    model_clear_state();
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      check(out_valid === 1'b0, "R8 no result while run low", longint'(out_valid), 0);
      check(in_ready === 1'b0, "R8 ready low while run low", longint'(in_ready), 0);
    end
    run = 1'b1;
    @(negedge clk);
    sample_check(6000, 2, "R8 fresh response, coefs kept");
    sample_check(0, 2, "R8 fresh response tail");
  endtask

  initial begin
    for (int s = 0; s < 25; s++) begin
      for (int k = 0; k < 5; k++) cm[s][k] = (k == 0) ? 16384 : 0;
    end
    model_clear_state();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_r7();
    t_count_r3();
    t_busy_ignore_r1();
    t_round_sat_r5();
    t_recursion_r4();
    t_cascade_r6();
    t_run_clear_r8();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule